// File: doc/BRIEF.md
# Prioritised Interrupt Controller With Trigger Modes

This block gathers sixteen external interrupt request lines and presents one of them to a processor. Software picks, per line, whether the line requests while low, requests while high, or requests once on a falling or rising transition. It also gives each line a priority level. Transition requests are held in a latch until software clears them through a command register. Each request line is first brought into the clock domain by a two-stage synchroniser.

A global threshold filters out low-priority work. Among the surviving requests the highest level wins, and a tie goes to the lowest line number. The winner's number and level appear in a status word, together with a flag that reads 0 while something is pending. A single interrupt output tells the processor that a winner exists. Registers are reached over a simple 32-bit bus with a byte address, a write strobe and a read strobe. Read data is combinational.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the interrupt output is low. Every register reads zero, except the current-status word at 0xA0, which reads 0x0001_0000.
- R2: The interrupt output and the pending flag are forced inactive while bit 0 of the enable register at 0x00 is clear.
- R3: Line n takes its 2-bit trigger field from the register at 0x04 (n<8) or 0x08 (n>=8), at bits (n mod 8)*2+1:(n mod 8)*2. The codes are 00 for low-active, 01 for high-active, 10 for falling edge and 11 for rising edge. In the two level codes the request follows the synchronised input.
- R4: In an edge code, the selected transition of the synchronised input sets a latch. The latch keeps the line requesting after the input returns, until the latch is cleared.
- R5: Line n's priority lane is bits 8*(n mod 2)+7:8*(n mod 2) of the register at 0x10+4*(n/2). A line whose level is 0 is never selected.
- R6: Only bits 2:0 of a lane count toward the level. A line is eligible only when its level is strictly greater than bits 2:0 of the threshold register at 0x40.
- R7: Among eligible lines the highest level wins, and ties go to the lowest line number.
- R8: The word at 0xA0 holds the winner's number in bits 4:0 and its level in bits 10:8. Bit 16 is 0 while an interrupt is pending and 1 otherwise, and when it is 1 the other bits are 0. The interrupt output equals the inverse of bit 16.
- R9: A write to 0x60 with bit 8 set clears the edge latch of the line numbered in bits 3:0. A write to 0x60 with bit 8 clear changes nothing.
- R10: The word at 0x80 returns the 16-bit raw request vector: latches and level requests combined, before threshold, priority or enable.
- R11: Registers read back only their defined bits: 1 bit of enable, 16 bits of each trigger and priority register, and 3 bits of threshold. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | External request lines, asynchronous |
| bus_addr_i | input | 8 | Byte address, word aligned |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, zero when no read |
| cpu_irq_o | output | 1 | Interrupt request to processor |

## Verification
The bench targets ties between equal levels, where a design that scanned from the top would report line 7 instead of line 6. It also targets a level equal to the threshold, which an off-by-one comparison would let through, and a lane value with bit 3 set, which a design comparing the whole lane would misjudge. Edge lines are pulsed briefly and then checked after the input has dropped. A design that passed the input through instead of latching would lose the request there. A clear command without bit 8 must leave the latch set, and a clear aimed at one line must leave other lines alone. Disabling the controller must hide the winner while the raw vector at 0x80 still shows it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned WORD_ENABLE = 'h00 >> 2;
  localparam int unsigned WORD_TRIG0  = 'h04 >> 2;
  localparam int unsigned WORD_PRIO0  = 'h10 >> 2;
  localparam int unsigned WORD_THRESH = 'h40 >> 2;
  localparam int unsigned WORD_CLRCMD = 'h60 >> 2;
  localparam int unsigned WORD_RAWPND = 'h80 >> 2;
  localparam int unsigned WORD_CURST  = 'hA0 >> 2;
  localparam int unsigned CLR_GO_BIT  = 8;
  localparam int unsigned LANE_W      = 8;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NSRC  = 16,
  parameter int LVL_W = 3,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [NSRC-1:0]        pend_i,
  input  logic [DW-1:0]          curst_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   enable_o,
  output logic [2*NSRC-1:0]      trig_o,
  output logic [LANE_W*NSRC-1:0] prio_o,
  output logic [LVL_W-1:0]       thresh_o,
  output logic [NSRC-1:0]        clr_o
);
  localparam int PER_TRIG = 8;
  localparam int PER_PRIO = 2;
  localparam int NTRIG    = NSRC / PER_TRIG;
  localparam int NPRIO    = NSRC / PER_PRIO;
  localparam int REG_USED = 16;
  localparam int IDX_W    = $clog2(NSRC);

  logic [AW-3:0] word;
  assign word = addr_i[AW-1:2];

  logic                   en_q, en_d;
  logic [2*NSRC-1:0]      trig_q, trig_d;
  logic [LANE_W*NSRC-1:0] prio_q, prio_d;
  logic [LVL_W-1:0]       th_q, th_d;

  always_comb begin
    en_d   = en_q;
    trig_d = trig_q;
    prio_d = prio_q;
    th_d   = th_q;
    if (wr_i) begin
      if (word == WORD_ENABLE) en_d = wdata_i[0];
      if (word == WORD_THRESH) th_d = wdata_i[LVL_W-1:0];
      for (int k = 0; k < NTRIG; k++)
        if (word == WORD_TRIG0 + k) trig_d[k*REG_USED +: REG_USED] = wdata_i[REG_USED-1:0];
      for (int k = 0; k < NPRIO; k++)
        if (word == WORD_PRIO0 + k) prio_d[k*REG_USED +: REG_USED] = wdata_i[REG_USED-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      trig_q <= '0;
      prio_q <= '0;
      th_q   <= '0;
    end else if (wr_i) begin
      en_q   <= en_d;
      trig_q <= trig_d;
      prio_q <= prio_d;
      th_q   <= th_d;
    end
  end

  // Clear command: one-cycle pulse aimed at a single line
  logic clr_go;
  assign clr_go = wr_i && (word == WORD_CLRCMD) && wdata_i[CLR_GO_BIT];

  generate
    for (genvar n = 0; n < NSRC; n++) begin : g_clr
      assign clr_o[n] = clr_go && (wdata_i[IDX_W-1:0] == IDX_W'(n));
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (word == WORD_ENABLE) rdata_o[0] = en_q;
      if (word == WORD_THRESH) rdata_o[LVL_W-1:0] = th_q;
      if (word == WORD_RAWPND) rdata_o[NSRC-1:0] = pend_i;
      if (word == WORD_CURST)  rdata_o = curst_i;
      for (int k = 0; k < NTRIG; k++)
        if (word == WORD_TRIG0 + k) rdata_o[REG_USED-1:0] = trig_q[k*REG_USED +: REG_USED];
      for (int k = 0; k < NPRIO; k++)
        if (word == WORD_PRIO0 + k) rdata_o[REG_USED-1:0] = prio_q[k*REG_USED +: REG_USED];
    end
  end

  assign enable_o = en_q;
  assign trig_o   = trig_q;
  assign prio_o   = prio_q;
  assign thresh_o = th_q;

  p_clr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o));
  p_clr_needs_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wdata_i[CLR_GO_BIT]) |-> (clr_o == '0));
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int NSRC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic [2*NSRC-1:0] trig_i,
  input  logic [NSRC-1:0]   clr_i,
  output logic [NSRC-1:0]   pend_o
);
  logic [NSRC-1:0] s1_q, s2_q, s3_q;
  logic [NSRC-1:0] lat_q, lat_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= req_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  generate
    for (genvar n = 0; n < NSRC; n++) begin : g_line
      logic is_edge, want_rise, rise, fall, hit;
      assign is_edge   = trig_i[2*n+1];
      assign want_rise = trig_i[2*n];
      assign rise      = s2_q[n] & ~s3_q[n];
      assign fall      = ~s2_q[n] & s3_q[n];
      assign hit       = is_edge & (want_rise ? rise : fall);
      // a new edge wins over a clear in the same cycle
      assign lat_d[n]  = hit | (lat_q[n] & ~clr_i[n]);
      assign pend_o[n] = is_edge ? lat_q[n] : (want_rise ? s2_q[n] : ~s2_q[n]);

      p_latch_only_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_q[n]) |-> $past(trig_i[2*n+1]));
      p_latch_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q[n] && !clr_i[n]) |=> lat_q[n]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int NSRC  = 16,
  parameter int LVL_W = 3,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic                   en_i,
  input  logic [NSRC-1:0]        pend_i,
  input  logic [LANE_W*NSRC-1:0] prio_i,
  input  logic [LVL_W-1:0]       thresh_i,
  output logic                   irq_o,
  output logic [IDX_W-1:0]       win_id_o,
  output logic [LVL_W-1:0]       win_lvl_o
);
  logic [NSRC-1:0] elig;

  generate
    for (genvar n = 0; n < NSRC; n++) begin : g_elig
      assign elig[n] = en_i & pend_i[n] & (prio_i[n*LANE_W +: LVL_W] > thresh_i);
    end
  endgenerate

  always_comb begin
    win_id_o  = '0;
    win_lvl_o = '0;
    // strict compare keeps the lowest index on a tie
    for (int n = 0; n < NSRC; n++) begin
      if (elig[n] && (prio_i[n*LANE_W +: LVL_W] > win_lvl_o)) begin
        win_id_o  = IDX_W'(n);
        win_lvl_o = prio_i[n*LANE_W +: LVL_W];
      end
    end
  end

  assign irq_o = |elig;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC  = 16,
  parameter int LVL_W = 3,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic            bus_wr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  input  logic            bus_rd_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            cpu_irq_o
);
  localparam int IDX_W     = $clog2(NSRC);
  localparam int ID_FIELD  = 5;
  localparam int LVL_SHIFT = 8;
  localparam int NONE_BIT  = 16;

  logic                   enable;
  logic [2*NSRC-1:0]      trig;
  logic [LANE_W*NSRC-1:0] prio;
  logic [LVL_W-1:0]       thresh;
  logic [NSRC-1:0]        clr, pend;
  logic                   irq;
  logic [IDX_W-1:0]       win_id;
  logic [LVL_W-1:0]       win_lvl;
  logic [DW-1:0]          curst;

  irqc_regs #(.NSRC(NSRC), .LVL_W(LVL_W), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .pend_i(pend), .curst_i(curst),
    .rdata_o(bus_rdata_o), .enable_o(enable), .trig_o(trig), .prio_o(prio),
    .thresh_o(thresh), .clr_o(clr)
  );

  irqc_detect #(.NSRC(NSRC)) u_detect (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .trig_i(trig),
    .clr_i(clr), .pend_o(pend)
  );

  irqc_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
    .en_i(enable), .pend_i(pend), .prio_i(prio), .thresh_i(thresh),
    .irq_o(irq), .win_id_o(win_id), .win_lvl_o(win_lvl)
  );

  always_comb begin
    curst = '0;
    curst[NONE_BIT] = ~irq;
    curst[LVL_SHIFT +: LVL_W] = win_lvl;
    curst[ID_FIELD-1:0] = ID_FIELD'(win_id);
  end

  assign cpu_irq_o = irq;

  p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !cpu_irq_o);
  p_winner_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o |-> (pend[win_id] && (prio[win_id*LANE_W +: LVL_W] > thresh)));
  p_none_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq_o |-> (win_id == '0 && win_lvl == '0));
  p_top_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o |-> (win_lvl != '0));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          errors = 0, checks = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rd_i(rd), .bus_rdata_o(rdata), .cpu_irq_o(irq)
  );

  // {request pattern, expected word at 0xA0}; all lines high-active, threshold 2
  localparam logic [47:0] VEC [10] = '{
    {16'h0000, 32'h0001_0000},
    {16'h0001, 32'h0001_0000},
    {16'h0003, 32'h0001_0000},
    {16'h0004, 32'h0000_0302},
    {16'h00C0, 32'h0000_0706},
    {16'h0080, 32'h0000_0707},
    {16'hFF00, 32'h0000_0308},
    {16'h8010, 32'h0000_0504},
    {16'h8000, 32'h0000_030F},
    {16'h0024, 32'h0000_0605}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic expect_state(input string tag, input logic [31:0] cur, input logic [15:0] raw);
    logic [31:0] v;
    bus_read(8'hA0, v); check({tag, " status"}, v, cur);
    bus_read(8'h80, v); check({tag, " raw"}, v, {16'h0, raw});
    check({tag, " irq"}, {31'h0, irq}, {31'h0, ~cur[16]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    bus_read(8'hA0, v); check("R1 curstatus", v, 32'h0001_0000);
    bus_read(8'h00, v); check("R1 enable", v, 32'h0);
    bus_read(8'h04, v); check("R1 trig0", v, 32'h0);
    bus_read(8'h2C, v); check("R1 prio7", v, 32'h0);
    bus_read(8'h40, v); check("R1 thresh", v, 32'h0);

    // R11 readback widths and unmapped space
    bus_write(8'h00, 32'hFFFF_FFFF); bus_read(8'h00, v); check("R11 enable", v, 32'h1);
    bus_write(8'h08, 32'hFFFF_FFFF); bus_read(8'h08, v); check("R11 trig1", v, 32'h0000_FFFF);
    bus_write(8'h14, 32'hFFFF_FFFF); bus_read(8'h14, v); check("R11 prio1", v, 32'h0000_FFFF);
    bus_write(8'h40, 32'hFFFF_FFFF); bus_read(8'h40, v); check("R11 thresh", v, 32'h7);
    bus_write(8'h0C, 32'hFFFF_FFFF); bus_read(8'h0C, v); check("R11 unmapped", v, 32'h0);

    // Configure: high-active everywhere, levels 1..7,7 then 3, threshold 2
    bus_write(8'h04, 32'h5555);
    bus_write(8'h08, 32'h5555);
    bus_write(8'h10, 32'h0201);
    bus_write(8'h14, 32'h0403);
    bus_write(8'h18, 32'h0605);
    bus_write(8'h1C, 32'h0707);
    for (int k = 0; k < 4; k++) bus_write(8'h20 + 8'(4*k), 32'h0303);
    bus_write(8'h40, 32'h2);
    bus_write(8'h00, 32'h1);

    // R3 R6 R7 R8 R10 vector table
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); req = VEC[i][47:32];
      settle();
      expect_state($sformatf("R7 vec%0d", i), VEC[i][31:0], VEC[i][47:32]);
    end

    // R2 disable hides winner, raw vector stays
    req = 16'h0004; settle();
    bus_write(8'h00, 32'h0);
    expect_state("R2 disabled", 32'h0001_0000, 16'h0004);
    bus_write(8'h00, 32'h1);
    expect_state("R2 reenabled", 32'h0000_0302, 16'h0004);

    // R6 level equal to threshold is not eligible
    bus_write(8'h40, 32'h3);
    expect_state("R6 equal", 32'h0001_0000, 16'h0004);
    // R6 bit 3 of lane ignored: lane 0x0B counts as 3
    bus_write(8'h40, 32'h2);
    bus_write(8'h14, 32'h040B);
    expect_state("R6 lane bit3", 32'h0000_0302, 16'h0004);
    // R5 level 0 disables
    bus_write(8'h14, 32'h0400);
    expect_state("R5 level zero", 32'h0001_0000, 16'h0004);
    bus_write(8'h14, 32'h0403);

    // R3 low-active on line 9 (trig1 bits 3:2 = 00)
    @(negedge clk); req = '0;
    bus_write(8'h08, 32'h5551);
    settle();
    expect_state("R3 low active", 32'h0000_0309, 16'h0200);
    @(negedge clk); req = 16'h0200; settle();
    expect_state("R3 low released", 32'h0001_0000, 16'h0000);
    bus_write(8'h08, 32'h5555);
    @(negedge clk); req = '0;

    // R4 rising edge on line 3, falling edge on line 4
    bus_write(8'h04, 32'h56D5);
    settle();
    expect_state("R4 idle", 32'h0001_0000, 16'h0000);
    @(negedge clk); req = 16'h0008;
    repeat (2) @(negedge clk); req = '0;
    settle();
    expect_state("R4 rise latched", 32'h0000_0403, 16'h0008);

    // R9 clear without go bit does nothing; wrong line does nothing
    bus_write(8'h60, 32'h0000_0003); settle();
    expect_state("R9 no go bit", 32'h0000_0403, 16'h0008);
    bus_write(8'h60, 32'h0000_0104); settle();
    expect_state("R9 other line", 32'h0000_0403, 16'h0008);
    bus_write(8'h60, 32'h0000_0103); settle();
    expect_state("R9 cleared", 32'h0001_0000, 16'h0000);

    // R4 falling edge: rising input does not latch, falling does
    @(negedge clk); req = 16'h0010; settle();
    expect_state("R4 fall wait", 32'h0001_0000, 16'h0000);
    @(negedge clk); req = '0; settle();
    expect_state("R4 fall latched", 32'h0000_0504, 16'h0010);
    bus_write(8'h60, 32'h0000_0104); settle();
    expect_state("R9 fall cleared", 32'h0001_0000, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule